// File: doc/BRIEF.md
# Configurable Logic-Array Output Cell

This block is a single output cell for a small sum-of-products logic device. It receives a set of product terms from the AND array. It ORs them and applies a programmable inversion. It then either presents the result straight to the pin or captures it in a D flip-flop on the rising clock edge. The same cell also chooses what drives the pin's tri-state enable and what signal returns to the array as feedback.

Three configuration bits choose the cell's personality. Two of them are shared by every cell of the device and one is local. The four personalities are a clocked output, a combinational pin whose enable comes from a product term, an always-driven combinational output, and a pure input whose driver is off. An asynchronous active-low reset is the power-up clear. A preload strobe lets a test force any value from the pin into the flip-flop. Two parameters adapt the instance for the cells at the ends of the row and for the cells that return no feedback when they are plain outputs.

Top module: `pla_out_cell`

## Requirements
- R1: With g_sel0=0, g_sel1=1, c_sel=0 the cell is clocked. pin_oe follows glb_oe, and pin_out shows the registered value.
- R2: At each rising clk edge without preload, the registered value becomes (OR of all product terms) XOR c_inv. It does not change between edges.
- R3: With g_sel1=1 and c_sel=1 the cell is combinational I/O. pin_oe equals terms[0], and pin_out is (OR of terms[N-1:1]) XOR c_inv, so terms[0] takes no part in the sum.
- R4: With g_sel0=1, g_sel1=0, c_sel=0, and also for the spare code g_sel0=1, g_sel1=1, c_sel=0, the cell is an always-on combinational output. pin_oe is 1 and pin_out is (OR of all terms) XOR c_inv.
- R5: With g_sel0=1, g_sel1=0, c_sel=1, and also for both codes with g_sel0=0, g_sel1=0, the cell is a dedicated input and pin_oe is 0.
- R6: c_inv=0 passes the sum unchanged and c_inv=1 presents its complement. This holds both combinationally and at the flip-flop input.
- R7: rst_n low clears the flip-flop at once. While the flip-flop is clear, a clocked-mode pin_out reads 1 whatever c_inv and the terms are.
- R8: With preload_en high at a rising edge, the registered value takes pin_in. The product terms and c_inv are ignored at that edge.
- R9: For an ordinary cell the feedback select bit is g_sel1. When it is 1 with c_sel=0, fb_out is the registered value. When it is 1 with c_sel=1, fb_out is pin_in. When it is 0, fb_out is nbr_pin_in.
- R10: For an end cell (END_CELL=1) the feedback select bit is g_sel0 in place of g_sel1. The rest of the R9 mapping is unchanged.
- R11: For a cell with NO_FB_OUT=1 in the always-on combinational output mode, fb_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flip-flop clock, rising edge |
| rst_n | input | 1 | Asynchronous power-up clear, active low |
| terms | input | N_TERMS | Product terms from the AND array |
| g_sel0 | input | 1 | Global bit: 1 disallows registers |
| g_sel1 | input | 1 | Global bit: registered-family emulation |
| c_sel | input | 1 | Local mode bit |
| c_inv | input | 1 | Local polarity bit, 1 = inverted |
| glb_oe | input | 1 | Global output enable, active high |
| preload_en | input | 1 | Test strobe: load pin_in into the flip-flop |
| pin_in | input | 1 | Value sensed on this cell's pin |
| nbr_pin_in | input | 1 | Value sensed on the adjacent cell's pin |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Tri-state driver enable |
| fb_out | output | 1 | Feedback into the AND array |

## Verification
The flip-flop has two sources that can meet at one rising edge: the preload path and the normal capture of the polarity-adjusted sum. The bench drives product terms whose capture would give the opposite of pin_in while the strobe is high. It then judges after the edge that pin_out carries pin_in. A second collision comes from the clear: reset is asserted between edges while the flip-flop holds 1 and a capture is pending. pin_out must go to 1 at once and stay there across the following edge.

// File: rtl/pla_cell_pkg.sv
package pla_cell_pkg;

    typedef enum logic [1:0] {
        CM_REG  = 2'd0,
        CM_CIO  = 2'd1,
        CM_COUT = 2'd2,
        CM_DIN  = 2'd3
    } cell_mode_e;

    typedef struct packed {
        logic store;
    } cell_reg_t;

    function automatic cell_mode_e decode_mode(input logic g0, input logic g1, input logic l0);
        cell_mode_e m;
        if (g1 && l0)        m = CM_CIO;
        else if (g1 && !g0)  m = CM_REG;
        else if (g1)         m = CM_COUT;
        else if (!g0)        m = CM_DIN;
        else if (l0)         m = CM_DIN;
        else                 m = CM_COUT;
        return m;
    endfunction

endpackage

// File: rtl/pla_mode_decode.sv
module pla_mode_decode
    import pla_cell_pkg::*;
(
    input  logic       g_sel0,
    input  logic       g_sel1,
    input  logic       c_sel,
    output cell_mode_e mode
);
    always_comb begin
        mode = decode_mode(g_sel0, g_sel1, c_sel);
    end
endmodule

// File: rtl/pla_term_sum.sv
module pla_term_sum #(
    parameter int N_TERMS = 8
) (
    input  logic [N_TERMS-1:0] terms,
    input  logic               drop_first,
    input  logic               c_inv,
    output logic               pol_val
);
    localparam int LAST = N_TERMS - 1;

    logic [N_TERMS-1:0] chain;

    assign chain[0] = terms[0] & ~drop_first;

    generate
        for (genvar i = 1; i <= LAST; i++) begin : g_or
            assign chain[i] = chain[i-1] | terms[i];
        end
    endgenerate

    assign pol_val = chain[LAST] ^ c_inv;
endmodule

// File: rtl/pla_cell_reg.sv
module pla_cell_reg
    import pla_cell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic d_val,
    input  logic preload_en,
    input  logic pin_in,
    output logic reg_val
);
    cell_reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (preload_en) st_d.store = ~pin_in;
        else            st_d.store = ~d_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_val = ~st_q.store;

    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_en |=> reg_val == $past(d_val)); // R2

    AST_PRELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en |=> reg_val == $past(pin_in)); // R8
endmodule

// File: rtl/pla_out_cell.sv
module pla_out_cell
    import pla_cell_pkg::*;
#(
    parameter int N_TERMS   = 8,
    parameter bit END_CELL  = 1'b0,
    parameter bit NO_FB_OUT = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TERMS-1:0] terms,
    input  logic               g_sel0,
    input  logic               g_sel1,
    input  logic               c_sel,
    input  logic               c_inv,
    input  logic               glb_oe,
    input  logic               preload_en,
    input  logic               pin_in,
    input  logic               nbr_pin_in,
    output logic               pin_out,
    output logic               pin_oe,
    output logic               fb_out
);
    cell_mode_e mode;
    logic       pol_val;
    logic       reg_val;
    logic       fb_sel;
    logic       fb_raw;

    pla_mode_decode u_dec (
        .g_sel0 (g_sel0),
        .g_sel1 (g_sel1),
        .c_sel  (c_sel),
        .mode   (mode)
    );

    pla_term_sum #(.N_TERMS(N_TERMS)) u_sum (
        .terms      (terms),
        .drop_first (mode == CM_CIO),
        .c_inv      (c_inv),
        .pol_val    (pol_val)
    );

    pla_cell_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .d_val      (pol_val),
        .preload_en (preload_en),
        .pin_in     (pin_in),
        .reg_val    (reg_val)
    );

    generate
        if (END_CELL) begin : g_fbsel_end
            assign fb_sel = g_sel0;
        end else begin : g_fbsel_mid
            assign fb_sel = g_sel1;
        end
    endgenerate

    always_comb begin
        unique case (mode)
            CM_REG:  pin_oe = glb_oe;
            CM_CIO:  pin_oe = terms[0];
            CM_COUT: pin_oe = 1'b1;
            default: pin_oe = 1'b0;
        endcase
        pin_out = (mode == CM_REG) ? reg_val : pol_val;
    end

    always_comb begin
        unique case ({fb_sel, c_sel})
            2'b10:   fb_raw = reg_val;
            2'b11:   fb_raw = pin_in;
            default: fb_raw = nbr_pin_in;
        endcase
    end

    generate
        if (NO_FB_OUT) begin : g_fb_cut
            assign fb_out = (mode == CM_COUT) ? 1'b0 : fb_raw;
            AST_NOFB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (g_sel0 && !g_sel1 && !c_sel) |-> !fb_out); // R11
        end else begin : g_fb_pass
            assign fb_out = fb_raw;
        end
    endgenerate

    AST_CIO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (g_sel1 && c_sel) |-> pin_oe == terms[0]); // R3

    AST_COUT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (g_sel0 && !g_sel1 && !c_sel) |-> pin_oe); // R4

    AST_DIN_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!g_sel1 && (!g_sel0 || c_sel)) |-> !pin_oe); // R5

    AST_REG_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!g_sel0 && g_sel1 && !c_sel) |-> (pin_oe == glb_oe)); // R1
endmodule

// File: tb/pla_out_cell_bench.sv
module pla_out_cell_bench;
    localparam int CLK_P = 10;
    localparam int NT = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic [NT-1:0] terms;
    logic g0, g1, l0, inv, oe, pre, pin, nbr;
    logic out_m, oe_m, fb_m;
    logic out_e, oe_e, fb_e;
    logic out_n, oe_n, fb_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    pla_out_cell #(.N_TERMS(NT)) u_pla_out_cell (
        .clk(clk), .rst_n(rst_n), .terms(terms), .g_sel0(g0), .g_sel1(g1),
        .c_sel(l0), .c_inv(inv), .glb_oe(oe), .preload_en(pre), .pin_in(pin),
        .nbr_pin_in(nbr), .pin_out(out_m), .pin_oe(oe_m), .fb_out(fb_m));

    pla_out_cell #(.N_TERMS(NT), .END_CELL(1'b1)) u_pla_out_cell_end (
        .clk(clk), .rst_n(rst_n), .terms(terms), .g_sel0(g0), .g_sel1(g1),
        .c_sel(l0), .c_inv(inv), .glb_oe(oe), .preload_en(pre), .pin_in(pin),
        .nbr_pin_in(nbr), .pin_out(out_e), .pin_oe(oe_e), .fb_out(fb_e));

    pla_out_cell #(.N_TERMS(NT), .NO_FB_OUT(1'b1)) u_pla_out_cell_nofb (
        .clk(clk), .rst_n(rst_n), .terms(terms), .g_sel0(g0), .g_sel1(g1),
        .c_sel(l0), .c_inv(inv), .glb_oe(oe), .preload_en(pre), .pin_in(pin),
        .nbr_pin_in(nbr), .pin_out(out_n), .pin_oe(oe_n), .fb_out(fb_n));

    typedef struct packed {
        logic       g0, g1, l0, inv;
        logic [7:0] t;
        logic       pin, nbr;
        logic       e_oe, e_out, e_fb, chk_fb;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0, 8'h00, 1'b0,1'b1, 1'b1,1'b0,1'b1,1'b1}, // R4 R9
        '{1'b1,1'b0,1'b0,1'b0, 8'h10, 1'b1,1'b0, 1'b1,1'b1,1'b0,1'b1}, // R4
        '{1'b1,1'b0,1'b0,1'b1, 8'h10, 1'b0,1'b1, 1'b1,1'b0,1'b1,1'b1}, // R6
        '{1'b1,1'b0,1'b1,1'b0, 8'hFF, 1'b1,1'b0, 1'b0,1'b1,1'b0,1'b1}, // R5
        '{1'b1,1'b0,1'b1,1'b0, 8'h00, 1'b0,1'b1, 1'b0,1'b0,1'b1,1'b1}, // R5
        '{1'b1,1'b1,1'b1,1'b0, 8'h01, 1'b0,1'b1, 1'b1,1'b0,1'b0,1'b1}, // R3
        '{1'b1,1'b1,1'b1,1'b0, 8'h03, 1'b1,1'b0, 1'b1,1'b1,1'b1,1'b1}, // R3
        '{1'b1,1'b1,1'b1,1'b1, 8'h80, 1'b0,1'b1, 1'b0,1'b0,1'b0,1'b1}, // R3 R6
        '{1'b0,1'b1,1'b1,1'b0, 8'hFE, 1'b1,1'b0, 1'b0,1'b1,1'b1,1'b1}, // R3 R9
        '{1'b0,1'b0,1'b0,1'b0, 8'h55, 1'b0,1'b1, 1'b0,1'b1,1'b1,1'b1}, // R5
        '{1'b1,1'b1,1'b0,1'b1, 8'h00, 1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0}  // R4
    };

    task automatic check(input logic act, input logic exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; terms = 8'hFF; g0 = 1'b0; g1 = 1'b1; l0 = 1'b0;
        inv = 1'b0; oe = 1'b1; pre = 1'b0; pin = 1'b0; nbr = 1'b0;
        #3;
        check(out_m, 1'b1, "R7 reset pin high inv=0");
        inv = 1'b1; #1;
        check(out_m, 1'b1, "R7 reset pin high inv=1");
        step(); step();
        check(out_m, 1'b1, "R7 held in reset across edges");
        rst_n = 1'b1;
        step();

        for (int i = 0; i < NV; i++) begin
            g0 = VECS[i].g0; g1 = VECS[i].g1; l0 = VECS[i].l0; inv = VECS[i].inv;
            terms = VECS[i].t; pin = VECS[i].pin; nbr = VECS[i].nbr;
            #1;
            check(oe_m, VECS[i].e_oe, $sformatf("R3/R4/R5 vec%0d pin_oe", i));
            check(out_m, VECS[i].e_out, $sformatf("R3/R4/R6 vec%0d pin_out", i));
            if (VECS[i].chk_fb) check(fb_m, VECS[i].e_fb, $sformatf("R9 vec%0d fb_out", i));
            step();
        end

        // clocked mode
        g0 = 1'b0; g1 = 1'b1; l0 = 1'b0; inv = 1'b0; oe = 1'b1; terms = 8'h01;
        step();
        check(out_m, 1'b1, "R2 capture sum=1");
        check(fb_m, out_m, "R9 fb is registered value");
        check(oe_m, 1'b1, "R1 pin_oe follows glb_oe=1");
        oe = 1'b0; #1;
        check(oe_m, 1'b0, "R1 pin_oe follows glb_oe=0");
        terms = 8'h00; #1;
        check(out_m, 1'b1, "R2 no change before edge");
        step();
        check(out_m, 1'b0, "R2 capture sum=0");
        check(fb_e, nbr, "R10 end cell clocked fb is neighbour");
        inv = 1'b1; step();
        check(out_m, 1'b1, "R6 inverted capture");
        inv = 1'b0; terms = 8'h80; step();
        check(out_m, 1'b1, "R2 top term capture");

        // preload against opposite capture
        pre = 1'b1; pin = 1'b0; terms = 8'hFF; step();
        check(out_m, 1'b0, "R8 preload 0 over sum 1");
        pin = 1'b1; terms = 8'h00; step();
        check(out_m, 1'b1, "R8 preload 1 over sum 0");
        pin = 1'b0; inv = 1'b1; terms = 8'h00; step();
        check(out_m, 1'b0, "R8 preload ignores polarity");
        pre = 1'b0;

        // asynchronous clear mid-cycle with capture pending
        inv = 1'b0; terms = 8'h00; #1;
        rst_n = 1'b0; #1;
        check(out_m, 1'b1, "R7 async clear drives pin high");
        step();
        check(out_m, 1'b1, "R7 stays high over edge in reset");
        rst_n = 1'b1; step();

        // end cell and no-feedback cell
        g0 = 1'b1; g1 = 1'b0; l0 = 1'b1; pin = 1'b1; nbr = 1'b0; #1;
        check(fb_e, 1'b1, "R10 end cell input mode fb from own pin");
        check(fb_m, 1'b0, "R9 ordinary cell input mode fb from neighbour");
        check(fb_n, 1'b0, "R11 no-fb cell input mode fb neighbour");
        l0 = 1'b0; nbr = 1'b1; #1;
        check(fb_n, 1'b0, "R11 no-fb cell output mode fb zero");
        check(fb_m, 1'b1, "R9 ordinary cell output mode fb neighbour");
        check(oe_n, 1'b1, "R4 no-fb cell driver on");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule